// File: doc/BRIEF.md
# SDRAM Single-Access Controller

This block serves one read or write per bus request to an external SDRAM. The requesting bus runs on `clk_bus` at one quarter of the memory clock `clk_mem`. A request crosses into the memory domain through a toggle handshake. The command state machine then opens a row, issues a single column command and closes the bank again with an explicit precharge. For reads it samples the device data a fixed three cycles after the read command and passes the word back to the bus domain. The device clock is an inverted copy of `clk_mem`, so the device samples commands in the middle of each controller cycle.

After reset the controller waits a power-up delay. It then precharges all banks, issues two auto-refresh commands and loads the mode register with burst length 1 and CAS latency 3. A free-running timer then asks for a refresh once every `REF_INTERVAL` cycles, and a pending refresh wins over a waiting access. Two static configuration inputs select the device size (2 MB or 8 MB) and the data width (8 or 16 bits). With an 8-bit device, each 16-bit bus access becomes two device accesses, low byte first.

Top module: `sdr_single_ctrl`

## Requirements
- R1: Only NOP (`sd_cmd` = 4'b0111) is driven until exactly `INIT_WAIT` `clk_mem` cycles after reset is released. Then, before any other command, the controller issues precharge-all (4'b0010 with `sd_addr[10]`=1), refresh (4'b0001), refresh, and mode load (4'b0000 with `sd_addr`=12'h030), in that order.
- R2: With a 16-bit device, the halfword address `ha` maps to column `ha[7:0]`, bank `ha[9:8]` and row `ha[21:10]`. Row bits 11:10 are forced to 0 when the 2 MB size is selected.
- R3: With an 8-bit device, the byte address b = {ha, part} maps to column `b[8:0]`, bank `b[10:9]` and row `b[22:11]`, with the same 2 MB row masking as R2.
- R4: A read (4'b0101) captures `sd_dq_i` at the third `clk_mem` edge after the edge that launched the read command. The captured word is returned on `bus_rdata`.
- R5: Write data is driven on `sd_dq_o` in the cycle of the write command (4'b0100). `sd_dq_oe` is high in that cycle only.
- R6: Every device access is an activate (4'b0011), then exactly one read or write to that bank at least 2 cycles later, then a precharge of that bank. No bank is activated while open, and refresh and mode load are issued only with all banks closed.
- R7: During normal operation a refresh is issued at least once every `REF_INTERVAL` plus one access length of cycles. When a refresh is pending and an access waits in the idle state, the refresh goes first.
- R8: With an 8-bit device, a bus access makes two device accesses: part 0 carries bits 7:0 and part 1 carries bits 15:8, each on `sd_dq_o[7:0]`. A read assembles the two bytes in the same order.
- R9: Each accepted request raises `bus_ack` for exactly one `clk_bus` cycle, with `bus_rdata` valid in that cycle. `sd_clk` is always the inverse of `clk_mem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mem | input | 1 | Memory-side command clock |
| clk_bus | input | 1 | Bus clock, one quarter of clk_mem, edge-aligned |
| rst | input | 1 | Synchronous active-high reset, held across both clocks |
| cfg_x8 | input | 1 | 1 selects an 8-bit device, 0 a 16-bit device |
| cfg_big | input | 1 | 1 selects 8 MB, 0 selects 2 MB |
| bus_req | input | 1 | Request, held until bus_ack |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 22 | Halfword address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| sd_clk | output | 1 | Device clock, inverted clk_mem |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row, column or mode word |
| sd_dq_o | output | 16 | Write data to device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_i | input | 16 | Read data from device |

## Verification
The bench builds the controller with `INIT_WAIT` = 40 and `REF_INTERVAL` = 150. These values make the power-up wait and the refresh period short enough to cover the whole initialisation sequence, several refresh gaps and an idle window of five refresh periods within a short run. All four size and width combinations are exercised against a behavioural device model. The model answers reads exactly three cycles after the read command, so capture in the wrong cycle returns a marker value instead of the stored data.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    localparam int HADDR_W = 22;
    localparam int DQ_W    = 16;
    localparam int SA_W    = 12;
    localparam int ROW_W   = 12;
    localparam int BA_W    = 2;
    localparam int COL_W   = 9;
    localparam int ROW_SMALL_W = 10;

    localparam int T_RP    = 2;
    localparam int T_RCD   = 2;
    localparam int T_RFC   = 7;
    localparam int T_MRD   = 2;
    localparam int T_WR    = 2;
    localparam int CAS_LAT = 3;
    localparam int WAIT_W  = $clog2(T_RFC);

    localparam logic [SA_W-1:0] MODE_WORD = 12'h030;  // BL1, sequential, CL3
    localparam logic [SA_W-1:0] PRE_ALL   = 12'h400;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_PWR, ST_IREF, ST_IMRS, ST_IDLE, ST_CMD, ST_PRE, ST_FIN
    } ctl_st_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [BA_W-1:0]  ba;
        logic [COL_W-1:0] col;
    } dev_loc_t;

    function automatic dev_loc_t map_loc(input logic [HADDR_W-1:0] ha,
                                         input logic part,
                                         input logic x8,
                                         input logic big);
        logic [HADDR_W:0] dw;
        dev_loc_t l;
        dw = x8 ? {ha, part} : {1'b0, ha};
        if (x8) begin
            l.col = dw[8:0];
            l.ba  = dw[10:9];
            l.row = dw[22:11];
        end else begin
            l.col = {1'b0, dw[7:0]};
            l.ba  = dw[9:8];
            l.row = dw[21:10];
        end
        if (!big) l.row[ROW_W-1:ROW_SMALL_W] = '0;
        return l;
    endfunction
endpackage

// File: rtl/sdr_tgl_sync.sv
module sdr_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], tgl_in};
    end

    assign pulse = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (cnt == CW'(INTERVAL - 1)) begin
                cnt  <= '0;
                tick <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdr_bus_if.sv
module sdr_bus_if
    import sdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [HADDR_W-1:0] bus_addr,
    input  logic [DQ_W-1:0]    bus_wdata,
    input  logic               done_pulse,
    input  logic [DQ_W-1:0]    mem_rdata,
    output logic               req_tgl,
    output logic               job_we,
    output logic [HADDR_W-1:0] job_addr,
    output logic [DQ_W-1:0]    job_wdata,
    output logic               bus_ack,
    output logic [DQ_W-1:0]    bus_rdata
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            req_tgl   <= 1'b0;
            job_we    <= 1'b0;
            job_addr  <= '0;
            job_wdata <= '0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= 1'b0;
            if (bus_req && !pending && !bus_ack) begin
                pending   <= 1'b1;
                req_tgl   <= ~req_tgl;
                job_we    <= bus_we;
                job_addr  <= bus_addr;
                job_wdata <= bus_wdata;
            end
            if (done_pulse) begin
                pending   <= 1'b0;
                bus_ack   <= 1'b1;
                bus_rdata <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
    import sdr_pkg::*;
#(
    parameter int INIT_WAIT = 20000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_x8,
    input  logic               cfg_big,
    input  logic               start,
    input  logic               job_we,
    input  logic [HADDR_W-1:0] job_addr,
    input  logic [DQ_W-1:0]    job_wdata,
    input  logic               ref_tick,
    input  logic [DQ_W-1:0]    sd_dq_i,
    output sd_cmd_e            cmd,
    output logic [BA_W-1:0]    ba,
    output logic [SA_W-1:0]    sa,
    output logic [DQ_W-1:0]    dq_o,
    output logic               dq_oe,
    output logic [DQ_W-1:0]    rdata,
    output logic               done_tgl,
    output logic               cap_en,
    output logic               idle_ready,
    output logic               ref_pend,
    output logic               job
);
    localparam int PW = $clog2(INIT_WAIT + 1);

    ctl_st_e           st;
    logic [WAIT_W-1:0] wt;
    logic [PW-1:0]     pwr_cnt;
    logic              iref_second;
    logic              part;
    dev_loc_t          loc;

    always_comb loc = map_loc(job_addr, part, cfg_x8, cfg_big);
    assign idle_ready = (st == ST_IDLE) && (wt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_PWR;
            wt          <= '0;
            pwr_cnt     <= '0;
            iref_second <= 1'b0;
            part        <= 1'b0;
            job         <= 1'b0;
            ref_pend    <= 1'b0;
            cmd         <= CMD_NOP;
            ba          <= '0;
            sa          <= '0;
            dq_o        <= '0;
            dq_oe       <= 1'b0;
            rdata       <= '0;
            done_tgl    <= 1'b0;
            cap_en      <= 1'b0;
        end else begin
            cmd    <= CMD_NOP;
            dq_oe  <= 1'b0;
            cap_en <= 1'b0;
            if (start) job <= 1'b1;
            if (wt != '0) begin
                wt <= wt - 1'b1;
            end else begin
                case (st)
                    ST_PWR: begin
                        if (pwr_cnt == PW'(INIT_WAIT - 1)) begin
                            cmd <= CMD_PRE;
                            sa  <= PRE_ALL;
                            wt  <= WAIT_W'(T_RP - 1);
                            st  <= ST_IREF;
                        end else begin
                            pwr_cnt <= pwr_cnt + 1'b1;
                        end
                    end
                    ST_IREF: begin
                        cmd         <= CMD_REF;
                        wt          <= WAIT_W'(T_RFC - 1);
                        iref_second <= 1'b1;
                        if (iref_second) st <= ST_IMRS;
                    end
                    ST_IMRS: begin
                        cmd <= CMD_MRS;
                        ba  <= '0;
                        sa  <= MODE_WORD;
                        wt  <= WAIT_W'(T_MRD - 1);
                        st  <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (ref_pend) begin
                            cmd      <= CMD_REF;
                            ref_pend <= 1'b0;
                            wt       <= WAIT_W'(T_RFC - 1);
                        end else if (job) begin
                            cmd <= CMD_ACT;
                            ba  <= loc.ba;
                            sa  <= loc.row;
                            wt  <= WAIT_W'(T_RCD - 1);
                            st  <= ST_CMD;
                        end
                    end
                    ST_CMD: begin
                        cmd   <= job_we ? CMD_WR : CMD_RD;
                        sa    <= {{(SA_W-COL_W){1'b0}}, loc.col};
                        dq_oe <= job_we;
                        if (cfg_x8)
                            dq_o <= {8'h00, part ? job_wdata[15:8] : job_wdata[7:0]};
                        else
                            dq_o <= job_wdata;
                        wt <= job_we ? WAIT_W'(T_WR - 1) : WAIT_W'(CAS_LAT - 1);
                        st <= ST_PRE;
                    end
                    ST_PRE: begin
                        cmd    <= CMD_PRE;
                        sa     <= '0;
                        cap_en <= !job_we;
                        if (!job_we) begin
                            if (!cfg_x8)   rdata       <= sd_dq_i;
                            else if (part) rdata[15:8] <= sd_dq_i[7:0];
                            else           rdata[7:0]  <= sd_dq_i[7:0];
                        end
                        wt <= WAIT_W'(T_RP - 1);
                        st <= ST_FIN;
                    end
                    ST_FIN: begin
                        if (cfg_x8 && !part) begin
                            part <= 1'b1;
                        end else begin
                            part     <= 1'b0;
                            job      <= 1'b0;
                            done_tgl <= ~done_tgl;
                        end
                        st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
            if (ref_tick) ref_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/sdr_single_ctrl.sv
module sdr_single_ctrl
    import sdr_pkg::*;
#(
    parameter int INIT_WAIT    = 20000,
    parameter int REF_INTERVAL = 1560,
    parameter int SYNC_STAGES  = 2
) (
    input  logic         clk_mem,
    input  logic         clk_bus,
    input  logic         rst,
    input  logic         cfg_x8,
    input  logic         cfg_big,
    input  logic         bus_req,
    input  logic         bus_we,
    input  logic [21:0]  bus_addr,
    input  logic [15:0]  bus_wdata,
    output logic         bus_ack,
    output logic [15:0]  bus_rdata,
    output logic         sd_clk,
    output logic [3:0]   sd_cmd,
    output logic [1:0]   sd_ba,
    output logic [11:0]  sd_addr,
    output logic [15:0]  sd_dq_o,
    output logic         sd_dq_oe,
    input  logic [15:0]  sd_dq_i
);
    logic               req_tgl, done_tgl, start, done_pulse, ref_tick;
    logic               job_we, cap_en, idle_ready, ref_pend, job;
    logic [HADDR_W-1:0] job_addr;
    logic [DQ_W-1:0]    job_wdata, mem_rdata;
    sd_cmd_e            cmd_q;

    assign sd_clk = ~clk_mem;
    assign sd_cmd = cmd_q;

    sdr_bus_if u_bus (
        .clk(clk_bus), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done_pulse(done_pulse),
        .mem_rdata(mem_rdata), .req_tgl(req_tgl), .job_we(job_we),
        .job_addr(job_addr), .job_wdata(job_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    sdr_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk_mem), .rst(rst), .tgl_in(req_tgl), .pulse(start)
    );

    sdr_tgl_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk_bus), .rst(rst), .tgl_in(done_tgl), .pulse(done_pulse)
    );

    sdr_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk_mem), .rst(rst), .tick(ref_tick)
    );

    sdr_cmd_fsm #(.INIT_WAIT(INIT_WAIT)) u_fsm (
        .clk(clk_mem), .rst(rst), .cfg_x8(cfg_x8), .cfg_big(cfg_big),
        .start(start), .job_we(job_we), .job_addr(job_addr),
        .job_wdata(job_wdata), .ref_tick(ref_tick), .sd_dq_i(sd_dq_i),
        .cmd(cmd_q), .ba(sd_ba), .sa(sd_addr), .dq_o(sd_dq_o),
        .dq_oe(sd_dq_oe), .rdata(mem_rdata), .done_tgl(done_tgl),
        .cap_en(cap_en), .idle_ready(idle_ready), .ref_pend(ref_pend),
        .job(job)
    );
endmodule

// File: rtl/sdr_single_ctrl_chk.sv
module sdr_single_ctrl_chk
    import sdr_pkg::*;
(
    input logic       clk_mem,
    input logic       clk_bus,
    input logic       rst,
    input logic [3:0] sd_cmd,
    input logic       sd_dq_oe,
    input logic       bus_ack,
    input logic       cap_en,
    input logic       idle_ready,
    input logic       ref_pend,
    input logic       job
);
    // R4: capture strobe comes three cycles after the read command left the block
    p_cl3_capture_r4: assert property (@(posedge clk_mem) disable iff (rst)
        cap_en |-> $past(sd_cmd, 3) == CMD_RD);

    // R5: data bus is driven only with a write command
    p_oe_only_write_r5: assert property (@(posedge clk_mem) disable iff (rst)
        sd_dq_oe |-> sd_cmd == CMD_WR);

    // R6: activate is followed by a NOP (row-to-column delay of two cycles)
    p_act_gap_r6: assert property (@(posedge clk_mem) disable iff (rst)
        sd_cmd == CMD_ACT |=> sd_cmd == CMD_NOP);

    // R7: a due refresh wins over a waiting access
    p_ref_first_r7: assert property (@(posedge clk_mem) disable iff (rst)
        (idle_ready && ref_pend && job) |=> sd_cmd == CMD_REF);

    // R9: acknowledge lasts one bus cycle
    p_ack_single_r9: assert property (@(posedge clk_bus) disable iff (rst)
        bus_ack |=> !bus_ack);
endmodule

bind sdr_single_ctrl sdr_single_ctrl_chk u_chk (
    .clk_mem(clk_mem), .clk_bus(clk_bus), .rst(rst), .sd_cmd(sd_cmd),
    .sd_dq_oe(sd_dq_oe), .bus_ack(bus_ack), .cap_en(cap_en),
    .idle_ready(idle_ready), .ref_pend(ref_pend), .job(job)
);

// File: tb/tb_sdr_single_ctrl.sv
module tb_sdr_single_ctrl;
    import sdr_pkg::*;

    localparam int INIT_WAIT    = 40;
    localparam int REF_INTERVAL = 150;
    localparam int REF_SLACK    = 40;

    logic        clk_mem = 1'b0, clk_bus = 1'b0, rst = 1'b1;
    logic        cfg_x8 = 1'b0, cfg_big = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [21:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] sd_dq_i = 16'hDEAD;
    logic        bus_ack, sd_clk, sd_dq_oe;
    logic [15:0] bus_rdata, sd_dq_o;
    logic [3:0]  sd_cmd;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;

    int tests = 0, fails = 0;
    int cyc = 0;

    sdr_single_ctrl #(.INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INTERVAL)) dut (
        .clk_mem(clk_mem), .clk_bus(clk_bus), .rst(rst), .cfg_x8(cfg_x8),
        .cfg_big(cfg_big), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .sd_clk(sd_clk), .sd_cmd(sd_cmd),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_o(sd_dq_o),
        .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
    );

    always #2 clk_mem = ~clk_mem;  // 250 MHz
    initial begin
        #2;
        forever begin clk_bus = 1'b1; #8; clk_bus = 1'b0; #8; end
    end

    always @(posedge clk_mem) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural device model and protocol observer
    logic [15:0] mem_m [longint];
    int open_row [4] = '{-1, -1, -1, -1};
    int act_cyc  [4] = '{0, 0, 0, 0};
    int rd_cnt = 0;
    logic [15:0] rd_val = '0;
    int first_seen = 0, init_idx = 0, mrs_seen = 0, last_ref = -1, ref_count = 0;
    int init_cmd [4];
    int init_adr [4];
    int q_ba[$], q_row[$], q_col[$], q_wr[$], q_dq[$];

    always @(negedge clk_mem) begin
        if (!rst) begin
            if (rd_cnt == 1) sd_dq_i = rd_val;
            else             sd_dq_i = 16'hDEAD;
            if (rd_cnt > 0) rd_cnt--;
            if (sd_dq_oe != (sd_cmd == CMD_WR)) chk(0, "R5", sd_dq_oe, sd_cmd == CMD_WR);
            if (sd_cmd != CMD_NOP) begin
                if (!first_seen) begin
                    chk(cyc == INIT_WAIT, "R1", cyc, INIT_WAIT);
                    first_seen = 1;
                end
                if (init_idx < 4) begin
                    init_cmd[init_idx] = int'(sd_cmd);
                    init_adr[init_idx] = int'(sd_addr);
                    init_idx++;
                end
                case (sd_cmd)
                    CMD_ACT: begin
                        chk(open_row[sd_ba] < 0, "R6", open_row[sd_ba], -1);
                        open_row[sd_ba] = int'(sd_addr);
                        act_cyc[sd_ba]  = cyc;
                    end
                    CMD_RD, CMD_WR: begin
                        longint key;
                        chk(open_row[sd_ba] >= 0 && cyc - act_cyc[sd_ba] >= T_RCD,
                            "R6", cyc - act_cyc[sd_ba], T_RCD);
                        key = (longint'(sd_ba) << 24) | (longint'(open_row[sd_ba]) << 9)
                              | longint'(sd_addr[8:0]);
                        q_ba.push_back(int'(sd_ba));
                        q_row.push_back(open_row[sd_ba]);
                        q_col.push_back(int'(sd_addr));
                        q_wr.push_back(sd_cmd == CMD_WR);
                        q_dq.push_back(int'(sd_dq_o));
                        if (sd_cmd == CMD_WR) begin
                            chk(sd_dq_oe == 1'b1, "R5", sd_dq_oe, 1);
                            mem_m[key] = sd_dq_o;
                        end else begin
                            rd_val = mem_m.exists(key) ? mem_m[key] : 16'h0000;
                            rd_cnt = 2;
                        end
                    end
                    CMD_PRE: begin
                        if (sd_addr[10]) begin
                            for (int b = 0; b < 4; b++) open_row[b] = -1;
                        end else begin
                            chk(open_row[sd_ba] >= 0, "R6", open_row[sd_ba], 0);
                            open_row[sd_ba] = -1;
                        end
                    end
                    CMD_REF, CMD_MRS: begin
                        int opn = 0;
                        for (int b = 0; b < 4; b++) if (open_row[b] >= 0) opn++;
                        chk(opn == 0, "R6", opn, 0);
                        if (sd_cmd == CMD_MRS) begin
                            mrs_seen = 1;
                            last_ref = cyc;
                        end else if (mrs_seen) begin
                            chk(cyc - last_ref <= REF_INTERVAL + REF_SLACK, "R7",
                                cyc - last_ref, REF_INTERVAL + REF_SLACK);
                            last_ref = cyc;
                            ref_count++;
                        end
                    end
                    default: chk(0, "R6", sd_cmd, CMD_NOP);
                endcase
            end
        end
    end

    task automatic exp_loc(input logic [21:0] a, input int part,
                           output int eb, output int er, output int ec);
        longint w;
        if (cfg_x8) begin
            w  = (longint'(a) << 1) | longint'(part);
            ec = int'(w & 'h1FF);
            eb = int'((w >> 9) & 3);
            er = int'((w >> 11) & 'hFFF);
        end else begin
            w  = longint'(a);
            ec = int'(w & 'hFF);
            eb = int'((w >> 8) & 3);
            er = int'((w >> 10) & 'hFFF);
        end
        if (!cfg_big) er = er & 'h3FF;
    endtask

    task automatic check_log(input bit we, input logic [21:0] a, input logic [15:0] wd);
        int np = cfg_x8 ? 2 : 1;
        string rq = cfg_x8 ? "R3" : "R2";
        for (int p = 0; p < np; p++) begin
            int eb, er, ec, gb, gr, gc, gw, gd;
            exp_loc(a, p, eb, er, ec);
            if (q_ba.size() == 0) begin
                chk(0, "R6", 0, 1);
            end else begin
                gb = q_ba.pop_front(); gr = q_row.pop_front(); gc = q_col.pop_front();
                gw = q_wr.pop_front(); gd = q_dq.pop_front();
                chk(gb == eb, rq, gb, eb);
                chk(gr == er, rq, gr, er);
                chk(gc == ec, (cfg_x8 ? "R8" : "R2"), gc, ec);
                chk(gw == int'(we), "R6", gw, we);
                if (we) begin
                    if (cfg_x8) chk(gd[7:0] == (p == 1 ? wd[15:8] : wd[7:0]), "R8",
                                    gd[7:0], (p == 1 ? wd[15:8] : wd[7:0]));
                    else        chk(gd[15:0] == wd, "R5", gd[15:0], wd);
                end
            end
        end
        chk(q_ba.size() == 0, "R6", q_ba.size(), 0);
    endtask

    task automatic access(input bit we, input logic [21:0] a, input logic [15:0] wd,
                          output logic [15:0] rd);
        int n = 0;
        @(negedge clk_bus);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        do begin
            @(negedge clk_bus);
            n++;
        end while (!bus_ack && n < 300);
        chk(bus_ack == 1'b1, "R9", bus_ack, 1);
        rd = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk_bus);
        chk(bus_ack == 1'b0, "R9", bus_ack, 0);
        check_log(we, a, wd);
    endtask

    task automatic run_cfg(input bit x8, input bit big, input logic [15:0] seed);
        logic [21:0] addrs [4] = '{22'h000000, 22'h0FFFFF, 22'h3ABCDE, 22'h155555};
        logic [15:0] rd;
        cfg_x8 = x8; cfg_big = big;
        for (int i = 0; i < 4; i++) access(1'b1, addrs[i], seed ^ (16'h1111 * 16'(i + 1)), rd);
        for (int i = 0; i < 4; i++) begin
            logic [15:0] e = seed ^ (16'h1111 * 16'(i + 1));
            access(1'b0, addrs[i], 16'h0, rd);
            chk(rd == e, (x8 ? "R8" : "R4"), rd, e);
        end
    endtask

    initial begin
        repeat (6) @(negedge clk_bus);
        // reset state
        chk(sd_cmd == CMD_NOP, "R1", sd_cmd, CMD_NOP);
        chk(bus_ack == 1'b0, "R9", bus_ack, 0);
        chk(sd_dq_oe == 1'b0, "R5", sd_dq_oe, 0);
        @(posedge clk_mem); #1;
        chk(sd_clk == 1'b0, "R9", sd_clk, 0);
        @(negedge clk_mem); #1;
        chk(sd_clk == 1'b1, "R9", sd_clk, 1);
        @(negedge clk_mem);
        rst = 1'b0;
        while (init_idx < 4) @(negedge clk_mem);
        chk(init_cmd[0] == CMD_PRE && init_adr[0][10], "R1", init_cmd[0], CMD_PRE);
        chk(init_cmd[1] == CMD_REF, "R1", init_cmd[1], CMD_REF);
        chk(init_cmd[2] == CMD_REF, "R1", init_cmd[2], CMD_REF);
        chk(init_cmd[3] == CMD_MRS && init_adr[3] == 'h030, "R1", init_adr[3], 'h030);

        run_cfg(1'b0, 1'b0, 16'hA5C3);
        run_cfg(1'b0, 1'b1, 16'h3C5A);
        run_cfg(1'b1, 1'b0, 16'h9E17);
        run_cfg(1'b1, 1'b1, 16'h7B20);

        // idle window: refresh keeps running
        begin
            int r0 = ref_count;
            repeat (5 * REF_INTERVAL) @(negedge clk_mem);
            chk(ref_count - r0 >= 4, "R7", ref_count - r0, 4);
            chk(cyc - last_ref <= REF_INTERVAL + REF_SLACK, "R7", cyc - last_ref, REF_INTERVAL);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule